// File: doc/BRIEF.md
# Auto-Reloading Interval Timer with Acknowledge

This block is a single down-counting interval timer controlled over a simple 32-bit register port. Software programs a 28-bit period and two enables into a control register. While the timer runs, each asserted `tick_en` cycle moves the count one step toward expiry. After exactly "period" ticks the timer raises a sticky interrupt flag and restarts on its own from the programmed period, so it keeps producing events at a fixed interval without software help.

A second, write-only register acknowledges events. One bit clears the flag and another restarts the interval early. The interrupt output is the flag gated by the interrupt enable. It feeds an external router, which is not part of this block. The tick strobe comes from outside, so the count rate is set by whoever drives `tick_en`. Tying it high makes one tick equal one core clock.

Top module: `tmr_reload_top`

## Requirements
- R1: After reset `irq_o` is 0 and the control register (offset 0x34) reads 0x00000000.
- R2: Writing the control register with bit 28 (run) set loads the count from bits [27:0] (period P). The flag, bit 31, is then first set after exactly P further ticks.
- R3: On expiry the count reloads from P without stopping, so with the flag cleared the next expiry follows P ticks after the previous one. The flag stays set until acknowledged.
- R4: The count only advances in cycles where `tick_en` is 1. Cycles without a tick have no effect on the time to expiry.
- R5: Writing the control register with bit 28 clear stops counting and no expiry occurs. A later write with bit 28 set restarts from the full period, not from where the count stopped.
- R6: A period of 0 never expires, however long the timer runs.
- R7: Writing the acknowledge register (offset 0x38) with bit 31 set clears the flag. If an expiry happens in the same cycle, the flag stays set.
- R8: Writing the acknowledge register with bit 30 set restarts the count from the full period while the timer runs. While the timer is stopped it has no effect.
- R9: `irq_o` equals the flag ANDed with bit 29 (interrupt enable). The flag is set and visible at bit 31 even when bit 29 is 0, and writing the control register leaves the flag unchanged.
- R10: The control register reads {flag, 0, bit29, bit28, period[27:0]}. Bits 31 and 30 of a control write are not stored. The acknowledge register and every other offset read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count strobe; one step per asserted cycle |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Flag ANDed with interrupt enable |

## Verification
The hardest case to reach from the ports is an expiry landing in the same cycle as a flag-clearing acknowledge. It needs the final tick and the bus write to meet on one clock edge. The bench reaches it with a period of 1 and an acknowledge issued in the cycle right after the first expiry is seen. That makes the next expiry coincide with the clear, so the flag must still be high when the write completes. For every other period in the sweep, the same acknowledge timing checks that the second interval is measured from the previous expiry and not from the acknowledge.

// File: rtl/tmr_pkg.sv
// Shared field positions and configuration type for the reloading timer.
// Assumes a 32-bit register word; bit positions are part of the software contract.
package tmr_pkg;
    localparam int REG_W    = 32;
    localparam int PERIOD_W = 28;
    localparam int FLAG_POS = 31;
    localparam int RLD_POS  = 30;
    localparam int IE_POS   = 29;
    localparam int RUN_POS  = 28;

    typedef struct packed {
        logic                ie;
        logic                run;
        logic [PERIOD_W-1:0] period;
    } tmr_cfg_t;
endpackage

// File: rtl/tmr_busif.sv
// Register port decode: turns writes into control/acknowledge strobes and
// builds the combinational read word. Assumes single-cycle write strobes.
module tmr_busif
    import tmr_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter logic [7:0]  CTRL_OFS = 8'h34,
    parameter logic [7:0]  ACK_OFS  = 8'h38
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  tmr_cfg_t          cfg_q,
    input  logic              flag_q,
    output logic              ctrl_wr,
    output tmr_cfg_t          wr_cfg,
    output logic              ack_clr,
    output logic              ack_rld,
    output logic [REG_W-1:0]  rdata
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] ACK_A  = ADDR_W'(ACK_OFS);

    logic ack_wr;

    // Decode write strobes per register.
    always_comb begin
        ctrl_wr = wr_en && (addr == CTRL_A);
        ack_wr  = wr_en && (addr == ACK_A);
        ack_clr = ack_wr && wdata[FLAG_POS];
        ack_rld = ack_wr && wdata[RLD_POS];
    end

    // Extract the storable control fields from the write word.
    always_comb begin
        wr_cfg.ie     = wdata[IE_POS];
        wr_cfg.run    = wdata[RUN_POS];
        wr_cfg.period = wdata[PERIOD_W-1:0];
    end

    // Read mux: only the control register returns data.
    always_comb begin
        if (addr == CTRL_A) rdata = {flag_q, 1'b0, cfg_q.ie, cfg_q.run, cfg_q.period};
        else                rdata = '0;
    end
endmodule

// File: rtl/tmr_cfg_regs.sv
// Holds the programmed enables and period. Cleared by reset, loaded by a control write.
module tmr_cfg_regs
    import tmr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ctrl_wr,
    input  tmr_cfg_t wr_cfg,
    output tmr_cfg_t cfg_q
);
    // Configuration storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg_q <= '0;
        else if (ctrl_wr) cfg_q <= wr_cfg;
    end
endmodule

// File: rtl/tmr_counter.sv
// Down counter with automatic reload. Expiry is the tick that moves the count
// off 1; a count of 0 never expires. Any register load in a cycle wins over counting.
module tmr_counter #(
    parameter int PERIOD_W = 28
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic                run_q,
    input  logic [PERIOD_W-1:0] period_q,
    input  logic                ctrl_wr,
    input  logic                wr_run,
    input  logic [PERIOD_W-1:0] wr_period,
    input  logic                ack_rld,
    output logic [PERIOD_W-1:0] count_q,
    output logic                expire
);
    localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

    logic load_ack;
    logic step;

    // Qualify loads and count steps for this cycle.
    always_comb begin
        load_ack = ack_rld && run_q && !ctrl_wr;
        step     = run_q && tick_en && !ctrl_wr && !load_ack && (count_q != '0);
        expire   = step && (count_q == ONE);
    end

    // Count register: control load, ack restart, reload on expiry, else decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)                 count_q <= '0;
        else if (ctrl_wr && wr_run) count_q <= wr_period;
        else if (load_ack)          count_q <= period_q;
        else if (expire)            count_q <= period_q;
        else if (step)              count_q <= count_q - ONE;
    end
endmodule

// File: rtl/tmr_flag.sv
// Sticky event flag: set by expiry, cleared by acknowledge; set has priority.
module tmr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic ack_clr,
    output logic flag_q
);
    // Flag register with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (expire)  flag_q <= 1'b1;
        else if (ack_clr) flag_q <= 1'b0;
    end
endmodule

// File: rtl/tmr_reload_top.sv
// Reloading interval timer top. Assumes tick_en is a single-cycle strobe in the
// clk domain; routing of irq_o happens outside.
module tmr_reload_top
    import tmr_pkg::*;
#(
    parameter int         ADDR_W   = 8,
    parameter logic [7:0] CTRL_OFS = 8'h34,
    parameter logic [7:0] ACK_OFS  = 8'h38
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_o
);
    tmr_cfg_t            cfg_q;
    tmr_cfg_t            wr_cfg;
    logic                ctrl_wr;
    logic                ack_clr;
    logic                ack_rld;
    logic                flag_q;
    logic                expire;
    logic [PERIOD_W-1:0] count_q;

    tmr_busif #(.ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .ACK_OFS(ACK_OFS)) u_bus (
        .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
        .cfg_q(cfg_q), .flag_q(flag_q),
        .ctrl_wr(ctrl_wr), .wr_cfg(wr_cfg), .ack_clr(ack_clr), .ack_rld(ack_rld),
        .rdata(reg_rdata)
    );

    tmr_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wr_cfg(wr_cfg), .cfg_q(cfg_q)
    );

    tmr_counter #(.PERIOD_W(PERIOD_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .run_q(cfg_q.run), .period_q(cfg_q.period),
        .ctrl_wr(ctrl_wr), .wr_run(wr_cfg.run), .wr_period(wr_cfg.period),
        .ack_rld(ack_rld), .count_q(count_q), .expire(expire)
    );

    tmr_flag u_flag (
        .clk(clk), .rst_n(rst_n), .expire(expire), .ack_clr(ack_clr), .flag_q(flag_q)
    );

    // Gate the flag with the interrupt enable.
    always_comb irq_o = flag_q && cfg_q.ie;
endmodule

// File: rtl/tmr_reload_chk.sv
// Assertion checker for the reloading timer, attached by bind.
module tmr_reload_chk #(
    parameter int         PERIOD_W = 28,
    parameter int         ADDR_W   = 8,
    parameter logic [7:0] ACK_OFS  = 8'h38
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick_en,
    input logic                run_q,
    input logic [PERIOD_W-1:0] period_q,
    input logic [PERIOD_W-1:0] count_q,
    input logic                ctrl_wr,
    input logic                ack_clr,
    input logic                ack_rld,
    input logic                expire,
    input logic                flag_q,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [31:0]         reg_rdata
);
    AST_RISE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(run_q)); // R2
    AST_COUNT_LE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (count_q <= period_q)); // R3
    AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !ctrl_wr && !ack_rld) |=> $stable(count_q)); // R4
    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !ctrl_wr) |=> $stable(count_q)); // R5
    AST_ZERO_NO_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == '0) |-> !expire); // R6
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_clr && !expire) |=> !flag_q); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag_q); // R7
    AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(ACK_OFS)) |-> (reg_rdata == '0)); // R10
endmodule

bind tmr_reload_top tmr_reload_chk #(
    .PERIOD_W(tmr_pkg::PERIOD_W), .ADDR_W(ADDR_W), .ACK_OFS(ACK_OFS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .run_q(cfg_q.run), .period_q(cfg_q.period), .count_q(count_q),
    .ctrl_wr(ctrl_wr), .ack_clr(ack_clr), .ack_rld(ack_rld),
    .expire(expire), .flag_q(flag_q),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/test_tmr_reload_top.sv
`timescale 1ns/1ps
module test_tmr_reload_top;
    localparam logic [7:0] CTRL = 8'h34;
    localparam logic [7:0] ACK  = 8'h38;
    localparam logic [31:0] IE  = 32'h2000_0000;
    localparam logic [31:0] RUN = 32'h1000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        irq_o;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tmr_reload_top i_tmr_reload_top (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = 32'h0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic wait_irq(input int lim, output int n);
        n = 0;
        while (!irq_o && n < lim) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic pulse();
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", {31'b0, irq_o}, 32'h0);
        rd(CTRL, v);
        check("R1 ctrl", v, 32'h0);

        // R2/R3/R7 sweep of periods 1..8
        for (int p = 1; p <= 8; p++) begin
            wr(CTRL, 32'h0);
            wr(ACK, 32'h8000_0000);
            wr(CTRL, IE | RUN | p);
            wait_irq(40, n);
            check("R2 first period", n, p);
            wr(ACK, 32'h8000_0000);
            wait_irq(40, n);
            // R7: with p=1 the expiry coincides with the clear and wins
            check("R3 R7 second period", n, p - 1);
        end

        // R8 ack restart while running
        wr(CTRL, 32'h0);
        wr(ACK, 32'h8000_0000);
        wr(CTRL, IE | RUN | 6);
        repeat (3) @(negedge clk);
        wr(ACK, 32'h4000_0000);
        wait_irq(40, n);
        check("R8 restart", n, 6);

        // R8 ack restart ignored while stopped
        wr(CTRL, 32'h0);
        wr(ACK, 32'h8000_0000);
        wr(CTRL, IE | 4);
        wr(ACK, 32'h4000_0000);
        repeat (20) @(negedge clk);
        check("R8 stopped irq", {31'b0, irq_o}, 32'h0);
        rd(CTRL, v);
        check("R8 stopped ctrl", v, IE | 4);

        // R5 stop then restart from full period
        wr(CTRL, IE | RUN | 5);
        repeat (2) @(negedge clk);
        wr(CTRL, IE | 5);
        repeat (20) @(negedge clk);
        check("R5 stopped", {31'b0, irq_o}, 32'h0);
        wr(CTRL, IE | RUN | 5);
        wait_irq(40, n);
        check("R5 restart", n, 5);

        // R6 zero period
        wr(CTRL, 32'h0);
        wr(ACK, 32'h8000_0000);
        wr(CTRL, IE | RUN);
        repeat (40) @(negedge clk);
        check("R6 irq", {31'b0, irq_o}, 32'h0);
        rd(CTRL, v);
        check("R6 flag", v, IE | RUN);

        // R4 tick gating
        tick_en = 1'b0;
        wr(CTRL, IE | RUN | 3);
        repeat (10) @(negedge clk);
        check("R4 no tick", {31'b0, irq_o}, 32'h0);
        pulse();
        pulse();
        check("R4 two ticks", {31'b0, irq_o}, 32'h0);
        pulse();
        check("R4 three ticks", {31'b0, irq_o}, 32'h1);
        tick_en = 1'b1;

        // R9 interrupt enable gating
        wr(CTRL, 32'h0);
        wr(ACK, 32'h8000_0000);
        wr(CTRL, RUN | 3);
        repeat (10) @(negedge clk);
        check("R9 masked irq", {31'b0, irq_o}, 32'h0);
        rd(CTRL, v);
        check("R9 flag visible", v, 32'h8000_0000 | RUN | 3);
        wr(CTRL, IE | RUN | 3);
        check("R9 flag kept on ctrl write", {31'b0, irq_o}, 32'h1);

        // R10 readback rules
        rd(ACK, v);
        check("R10 ack reads 0", v, 32'h0);
        rd(8'h24, v);
        check("R10 other offset", v, 32'h0);
        wr(CTRL, 32'h0);
        wr(ACK, 32'h8000_0000);
        wr(CTRL, 32'hC000_0005);
        rd(CTRL, v);
        check("R10 top bits not stored", v, 32'h0000_0005);
        check("R10 irq", {31'b0, irq_o}, 32'h0);

        finish_run();
    end
endmodule